// File: doc/BRIEF.md
# Processor Interrupt Input Conditioner

This block sits between a handful of external processor control pins and a CPU core. It turns pin activity into internal interrupt requests and one-cycle control actions. Pin activity arrives as update events: a pin index and a new level, already synchronised to the block clock. The block keeps the last level seen on every pin. It acts only when an update actually changes that level, so an identical level presented again has no effect.

Each known pin has its own sensitivity. The external interrupt, system management interrupt and soft reset follow their level into bits of a pending mask. The machine check input reacts only to a falling change, which sets its pending bit. Checkstop and hard reset are active-low, and their assertion produces a halt pulse or a system reset request pulse. The time-base enable input produces a start pulse when it rises and a stop pulse when it falls.

The aggregate interrupt request stays high while any pending bit is set. The core clears pending bits through a one-hot acknowledge mask. If a new set and an acknowledge reach the same bit in the same cycle, the set wins.

Top module: `irq_pin_conditioner`

## Requirements
- R1: An update whose level equals the stored level of that pin produces no pulse and no pending change, and leaves the stored levels unchanged.
- R2: Every valid update stores its level for the addressed pin, visible on `pin_level` the cycle after. Reset loads `pin_level` = 8'h18, so pins 3 and 4 read high and all others low.
- R3: Pin 0 (external interrupt) and pin 1 (system management interrupt) are active-high levels. A rising change sets pending bit 0 or bit 1 respectively, and a falling change clears it.
- R4: Pin 5 (soft reset) is an active-high level. It sets pending bit 3 on a rising change and clears it on a falling change.
- R5: Pin 2 (machine check) sets pending bit 2 on a falling change only. A rising change has no effect.
- R6: Pin 3 (checkstop, active low) gives a one-cycle `core_halt_pulse` on a falling change and raises `core_halted`. `core_halted` then stays high until the block reset, and a rising change on pin 3 does nothing.
- R7: Pin 4 (hard reset, active low) gives a one-cycle `sys_reset_pulse` on a falling change. A rising change does nothing.
- R8: Pin 6 (time-base enable) gives `tb_start_pulse` on a rising change and `tb_stop_pulse` on a falling change.
- R9: `irq_req` is high exactly when `pend_mask` is non-zero.
- R10: Each `ack_mask` bit clears the pending bit of the same position in the next cycle. A set that reaches the same bit in that cycle takes priority and leaves the bit set.
- R11: Pin index 7 is unknown. It produces no pulse and no pending change, but its level is still stored.
- R12: All action pulses are registered. Each is high for exactly the cycle after the update edge that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| upd_valid | input | 1 | Pin update present this cycle |
| upd_pin | input | 3 | Index of the updated pin |
| upd_level | input | 1 | New level of that pin |
| ack_mask | input | 4 | One-hot clear of pending bits from the core |
| pin_level | output | 8 | Stored last level of every pin |
| pend_mask | output | 4 | Pending interrupt bits (0 ext, 1 smi, 2 mchk, 3 soft reset) |
| irq_req | output | 1 | Aggregate interrupt request |
| core_halt_pulse | output | 1 | Checkstop assertion pulse |
| core_halted | output | 1 | Core halted until block reset |
| sys_reset_pulse | output | 1 | System reset request pulse |
| tb_start_pulse | output | 1 | Time-base start pulse |
| tb_stop_pulse | output | 1 | Time-base freeze pulse |

## Verification
A pin event that sets a pending bit can fall in the same cycle as a core acknowledge that clears that bit or a neighbouring one. The bench sweeps every pin index through repeated and changing levels, and rotates the acknowledge mask across all bit positions on those same update cycles. This includes one directed case where pin 0 rises while bit 0 is acknowledged. A model in the bench computes the next pending mask as the old mask minus the cleared and acknowledged bits, plus the set bits. The bench compares this against the ports one cycle after each update.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  localparam int NUM_PINS  = 8;
  localparam int PIN_IW    = $clog2(NUM_PINS);
  localparam int NUM_PEND  = 4;

  // pin indices
  localparam int PIN_EXT    = 0;
  localparam int PIN_SMI    = 1;
  localparam int PIN_MCHK   = 2;
  localparam int PIN_CSTOP  = 3;
  localparam int PIN_HRST   = 4;
  localparam int PIN_SRST   = 5;
  localparam int PIN_TBEN   = 6;

  // pending bit positions
  localparam int PB_EXT  = 0;
  localparam int PB_SMI  = 1;
  localparam int PB_MCHK = 2;
  localparam int PB_SRST = 3;

  // active-low pins idle high
  localparam logic [NUM_PINS-1:0] PIN_RST_LEVELS =
    NUM_PINS'((1 << PIN_CSTOP) | (1 << PIN_HRST));
endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter logic [N-1:0] RST_LEVELS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic [IW-1:0] upd_pin,
  input  logic          upd_level,
  output logic [N-1:0]  level_q,
  output logic          chg
);
  logic [N-1:0] level_d;
  logic [N-1:0] hit;
  logic         cur;

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign hit[i]     = upd_valid && (upd_pin == IW'(i));
    assign level_d[i] = hit[i] ? upd_level : level_q[i];
  end

  always_comb begin
    cur = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) cur = level_q[i];
    end
  end

  assign chg = (|hit) && (upd_level != cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          level_q <= RST_LEVELS;
    else if (upd_valid)  level_q <= level_d;
  end

  // R1
  repeat_level_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg) |=> $stable(level_q));
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] ack_mask,
  output logic [W-1:0] pend_q,
  output logic         irq_req
);
  logic [W-1:0] pend_d;
  logic         pend_en;

  always_comb begin
    pend_en = (|set_mask) || (|clr_mask) || (|ack_mask);
    pend_d  = (pend_q & ~clr_mask & ~ack_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign irq_req = |pend_q;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((pend_q & $past(set_mask)) == $past(set_mask)));
  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_mask & ~set_mask)) |=> ((pend_q & $past(ack_mask & ~set_mask)) == '0));
  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_mask));
endmodule

// File: rtl/irq_action_gen.sv
module irq_action_gen #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chg,
  input  logic [IW-1:0] upd_pin,
  input  logic          upd_level,
  output logic          halt_pulse,
  output logic          halted,
  output logic          sysrst_pulse,
  output logic          tbs_pulse,
  output logic          tbp_pulse
);
  import irq_cond_pkg::*;

  logic halt_d, sysrst_d, tbs_d, tbp_d, halted_d;

  always_comb begin
    halt_d   = chg && !upd_level && (upd_pin == IW'(PIN_CSTOP));
    sysrst_d = chg && !upd_level && (upd_pin == IW'(PIN_HRST));
    tbs_d    = chg &&  upd_level && (upd_pin == IW'(PIN_TBEN));
    tbp_d    = chg && !upd_level && (upd_pin == IW'(PIN_TBEN));
    halted_d = halted || halt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_pulse   <= 1'b0;
      sysrst_pulse <= 1'b0;
      tbs_pulse    <= 1'b0;
      tbp_pulse    <= 1'b0;
      halted       <= 1'b0;
    end else begin
      halt_pulse   <= halt_d;
      sysrst_pulse <= sysrst_d;
      tbs_pulse    <= tbs_d;
      tbp_pulse    <= tbp_d;
      halted       <= halted_d;
    end
  end

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R12
  halt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_pulse |=> !halt_pulse);
  // R8
  tb_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tbs_pulse && tbp_pulse));
  // R7
  sysrst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_pulse |=> !sysrst_pulse);
endmodule

// File: rtl/irq_pin_conditioner.sv
module irq_pin_conditioner
  import irq_cond_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_valid,
  input  logic [PIN_IW-1:0]   upd_pin,
  input  logic                upd_level,
  input  logic [NUM_PEND-1:0] ack_mask,
  output logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PEND-1:0] pend_mask,
  output logic                irq_req,
  output logic                core_halt_pulse,
  output logic                core_halted,
  output logic                sys_reset_pulse,
  output logic                tb_start_pulse,
  output logic                tb_stop_pulse
);
  logic                chg;
  logic                rise, fall;
  logic [NUM_PEND-1:0] set_mask, clr_mask;

  irq_pin_tracker #(.N(NUM_PINS), .IW(PIN_IW), .RST_LEVELS(PIN_RST_LEVELS)) u_track (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_pin(upd_pin),
    .upd_level(upd_level), .level_q(pin_level), .chg(chg));

  always_comb begin
    rise     = chg &&  upd_level;
    fall     = chg && !upd_level;
    set_mask = '0;
    clr_mask = '0;
    if (upd_pin == PIN_IW'(PIN_EXT)) begin
      set_mask[PB_EXT] = rise;
      clr_mask[PB_EXT] = fall;
    end
    if (upd_pin == PIN_IW'(PIN_SMI)) begin
      set_mask[PB_SMI] = rise;
      clr_mask[PB_SMI] = fall;
    end
    if (upd_pin == PIN_IW'(PIN_MCHK)) begin
      set_mask[PB_MCHK] = fall;
    end
    if (upd_pin == PIN_IW'(PIN_SRST)) begin
      set_mask[PB_SRST] = rise;
      clr_mask[PB_SRST] = fall;
    end
  end

  irq_pending_reg #(.W(NUM_PEND)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .ack_mask(ack_mask), .pend_q(pend_mask), .irq_req(irq_req));

  irq_action_gen #(.IW(PIN_IW)) u_act (
    .clk(clk), .rst_n(rst_n), .chg(chg), .upd_pin(upd_pin), .upd_level(upd_level),
    .halt_pulse(core_halt_pulse), .halted(core_halted),
    .sysrst_pulse(sys_reset_pulse), .tbs_pulse(tb_start_pulse),
    .tbp_pulse(tb_stop_pulse));

  // R9
  irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> irq_req);
endmodule

// File: tb/irq_pin_conditioner_tb.sv
module irq_pin_conditioner_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       upd_valid;
  logic [2:0] upd_pin;
  logic       upd_level;
  logic [3:0] ack_mask;
  logic [7:0] pin_level;
  logic [3:0] pend_mask;
  logic       irq_req, core_halt_pulse, core_halted, sys_reset_pulse;
  logic       tb_start_pulse, tb_stop_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_lv;
  logic [3:0] m_pend;
  logic       m_halted;

  always #2.5 clk = ~clk;

  irq_pin_conditioner u_dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_pin(upd_pin),
    .upd_level(upd_level), .ack_mask(ack_mask), .pin_level(pin_level),
    .pend_mask(pend_mask), .irq_req(irq_req), .core_halt_pulse(core_halt_pulse),
    .core_halted(core_halted), .sys_reset_pulse(sys_reset_pulse),
    .tb_start_pulse(tb_start_pulse), .tb_stop_pulse(tb_stop_pulse));

  function automatic logic [18:0] observed();
    return {pin_level, pend_mask, irq_req, core_halt_pulse, sys_reset_pulse,
            tb_start_pulse, tb_stop_pulse, core_halted};
  endfunction

  task automatic check(string tag, logic [18:0] exp);
    logic [18:0] act;
    act = observed();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; upd_valid = 1'b0; upd_pin = '0; upd_level = 1'b0; ack_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    m_lv = 8'h18; m_pend = '0; m_halted = 1'b0;
    @(negedge clk);
    // R2 reset state
    check("R2 reset", {8'h18, 4'h0, 1'b0, 4'b0, 1'b0});
  endtask

  task automatic upd(input int p, input logic l, input logic [3:0] a, input string tag);
    logic chg, rise, fall, hp, sp, ts, tp;
    logic [3:0] setm, clrm;
    string t;
    chg  = (l != m_lv[p]);
    rise = chg && l;
    fall = chg && !l;
    setm = '0; clrm = '0;
    if (p == 0) begin setm[0] = rise; clrm[0] = fall; end
    if (p == 1) begin setm[1] = rise; clrm[1] = fall; end
    if (p == 2) setm[2] = fall;
    if (p == 5) begin setm[3] = rise; clrm[3] = fall; end
    hp = (p == 3) && fall;
    sp = (p == 4) && fall;
    ts = (p == 6) && rise;
    tp = (p == 6) && fall;
    m_pend   = (m_pend & ~clrm & ~a) | setm;
    m_halted = m_halted | hp;
    m_lv[p]  = l;
    if (tag != "") t = tag;
    else if (!chg) t = "R1";
    else case (p)
      0, 1: t = "R3";
      2: t = "R5";
      3: t = "R6";
      4: t = "R7";
      5: t = "R4";
      6: t = "R8";
      default: t = "R11";
    endcase
    @(negedge clk);
    upd_valid = 1'b1; upd_pin = 3'(p); upd_level = l; ack_mask = a;
    @(negedge clk);
    upd_valid = 1'b0; ack_mask = '0;
    check({t, " R9 R2"}, {m_lv, m_pend, |m_pend, hp, sp, ts, tp, m_halted});
    @(negedge clk);
    // R12 pulses last one cycle
    check("R12", {m_lv, m_pend, |m_pend, 4'b0, m_halted});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // sweep: every pin, repeated and changing levels, rotating acknowledges
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 8; p++) begin
        for (int k = 0; k < 3; k++) begin
          logic base;
          logic [3:0] a;
          int sel;
          base = r[0] ^ r[1];
          sel = (p + k + r) % 5;
          a = (sel < 4) ? 4'(1 << sel) : 4'b0;
          upd(p, (k == 1) ? ~base : base, a, "");
        end
      end
    end
    // R10 collision: pin 0 rises while bit 0 acknowledged
    upd(0, 1'b0, 4'b0001, "R10 prep");
    upd(0, 1'b1, 4'b0001, "R10 set-vs-ack");
    upd(0, 1'b1, 4'b0001, "R10 ack-only");
    // R5 rising machine check has no effect, falling sets
    upd(2, 1'b1, 4'b0100, "R5 rise");
    upd(2, 1'b0, 4'b0000, "R5 fall");
    // R11 unknown pin stores level
    upd(7, 1'b1, 4'b0000, "R11 store");
    // R6 halted cleared only by reset
    upd(3, 1'b0, 4'b0000, "R6 halt");
    upd(3, 1'b1, 4'b0000, "R6 release");
    do_reset();
    check("R6 after reset", {8'h18, 4'h0, 1'b0, 4'b0, 1'b0});
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule